// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block sits between the serial control port of a two-channel volume stage and the switch array that sets each channel's gain. The serial port loads a new gain code for every channel and raises an update strobe. This controller then decides when each channel's active code takes the new value.

With zero-cross gating off, a new code takes effect at once. With gating on, the change waits on that channel until its input signal has crossed zero twice. An external comparator reports the signal's sign, and the controller counts two sign changes. If sixteen 1 ms ticks pass first, the change is forced through anyway. A gain code of zero means the channel is muted. An active-low mute pin silences both channels, and each channel goes quiet at its own next crossing or timeout. While chip select is asserted, a mute request from the pin is held back until chip select is released.

Beside each raw active code, the block gives the gain as a signed count of half-dB steps, with zero meaning unity gain. It also gives a per-channel mute flag.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset, every active code is 0, every mute flag is 1 and every half-dB output is 0.
- R2: With zero-cross gating off and the mute pin inactive, an update strobe makes the strobed codes active two clock cycles later.
- R3: With gating on, a changed code stays pending until two sign changes of that channel's synchronised sign bit have been seen. A single sign change does not apply it.
- R4: A pending change is applied on the sixteenth 1 ms tick after it became pending, even without two crossings. Fifteen ticks are not enough.
- R5: A new strobe that alters a pending target discards the crossings and ticks counted so far, and the count starts again for the new code.
- R6: Code 0 on a channel sets that channel's mute flag. Any non-zero code clears it.
- R7: While chip select (active low) is asserted, the mute pin has no effect. The request is taken in only once chip select is high.
- R8: An accepted mute-pin request drives both channels to code 0. Each channel does so after one sign change of its own or after a timeout, whether gating is on or off. Releasing the pin with gating off restores the programmed codes.
- R9: The half-dB output equals N - 192 as a 9-bit two's-complement value for code N from 1 to 255 (255 gives +63, 1 gives -191). It is 0 while the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zc_en_i | input | 1 | Zero-cross gating enable |
| mute_ni | input | 1 | Mute pin, active low |
| cs_ni | input | 1 | Chip select of the serial port, active low |
| upd_i | input | 1 | One-cycle strobe that loads all channel codes |
| pend_code_i | input | 16 | New codes; channel c in bits [8c+7:8c] |
| sign_i | input | 2 | Input sign per channel, asynchronous |
| tick_ms_i | input | 1 | One-cycle 1 ms tick |
| act_code_o | output | 16 | Active codes, same packing as pend_code_i |
| half_db_o | output | 18 | Signed half-dB gain per channel, 9 bits each |
| mute_o | output | 2 | Channel muted (active code is 0) |

## Verification
The bench goes after the pending window. A design that applied a change on the first crossing, or that counted crossings across channels, would change the gain one crossing early. It also checks the timeout edge: an off-by-one tick counter would switch at fifteen ticks or wait for seventeen. A replacement strobe must restart the wait, and a design that kept the old count would apply the second code after a single further crossing. Mute requests made under an asserted chip select are checked for leakage. Muting too early would cut audio in the middle of a transfer. The half-dB mapping is checked at both ends of the code range, where an offset or sign-extension error shows first.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned HDB_W  = 9;
  localparam int unsigned UNITY  = 192;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/zc_sign_sync.sv
module zc_sign_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sign_i,
  output logic xing_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sign_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign xing_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/zc_mute_gate.sv
module zc_mute_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mute_ni,
  input  logic cs_ni,
  output logic mute_req_o
);
  // pin is sampled only while the serial port is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mute_req_o <= 1'b0;
    else if (cs_ni) mute_req_o <= ~mute_ni;
  end
endmodule

// File: rtl/zc_chan.sv
module zc_chan
  import zc_pkg::*;
#(
  parameter int unsigned TMO_TICKS = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  zc_en_i,
  input  logic  mute_req_i,
  input  logic  upd_i,
  input  code_t new_code_i,
  input  logic  xing_i,
  input  logic  tick_i,
  output code_t act_o
);
  localparam int unsigned TMO_W = $clog2(TMO_TICKS + 1);

  code_t            code_q, tgt_q, target;
  logic             busy_q;
  logic [1:0]       xcnt_q, need;
  logic [TMO_W-1:0] tmo_q;
  logic             gated, hit_x, hit_t;

  assign target = mute_req_i ? '0 : code_q;
  assign gated  = zc_en_i | mute_req_i;
  assign need   = mute_req_i ? 2'd1 : 2'd2;
  assign hit_x  = xing_i && ((xcnt_q + 2'd1) >= need);
  assign hit_t  = tick_i && (tmo_q == TMO_W'(TMO_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      tgt_q  <= '0;
      act_o  <= '0;
      busy_q <= 1'b0;
      xcnt_q <= '0;
      tmo_q  <= '0;
    end else begin
      if (upd_i) code_q <= new_code_i;
      if (target == act_o) begin
        busy_q <= 1'b0;
      end else if (!gated) begin
        act_o  <= target;
        busy_q <= 1'b0;
      end else if (!busy_q || target != tgt_q) begin
        // new or replaced target: restart the wait
        busy_q <= 1'b1;
        tgt_q  <= target;
        xcnt_q <= '0;
        tmo_q  <= '0;
      end else begin
        if (xing_i) xcnt_q <= xcnt_q + 2'd1;
        if (tick_i) tmo_q  <= tmo_q + 1'b1;
        if (hit_x || hit_t) begin
          act_o  <= tgt_q;
          busy_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
  import zc_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned TMO_TICKS   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  zc_en_i,
  input  logic                  mute_ni,
  input  logic                  cs_ni,
  input  logic                  upd_i,
  input  logic [NCH*CODE_W-1:0] pend_code_i,
  input  logic [NCH-1:0]        sign_i,
  input  logic                  tick_ms_i,
  output logic [NCH*CODE_W-1:0] act_code_o,
  output logic [NCH*HDB_W-1:0]  half_db_o,
  output logic [NCH-1:0]        mute_o
);
  logic           mute_req;
  logic [NCH-1:0] xing;

  zc_mute_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mute_ni    (mute_ni),
    .cs_ni      (cs_ni),
    .mute_req_o (mute_req)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    code_t act;

    zc_sign_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sign_i (sign_i[c]),
      .xing_o (xing[c])
    );

    zc_chan #(.TMO_TICKS(TMO_TICKS)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .zc_en_i    (zc_en_i),
      .mute_req_i (mute_req),
      .upd_i      (upd_i),
      .new_code_i (pend_code_i[c*CODE_W +: CODE_W]),
      .xing_i     (xing[c]),
      .tick_i     (tick_ms_i),
      .act_o      (act)
    );

    assign act_code_o[c*CODE_W +: CODE_W] = act;
    assign mute_o[c] = (act == '0);
    assign half_db_o[c*HDB_W +: HDB_W] =
      (act == '0) ? '0 : ({1'b0, act} - HDB_W'(UNITY));
  end
endmodule

// File: rtl/zc_gain_ctrl_chk.sv
module zc_gain_ctrl_chk
  import zc_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  zc_en_i,
  input logic                  cs_ni,
  input logic                  tick_ms_i,
  input logic                  mute_req,
  input logic [NCH-1:0]        xing,
  input logic [NCH*CODE_W-1:0] act_code_o,
  input logic [NCH*HDB_W-1:0]  half_db_o,
  input logic [NCH-1:0]        mute_o
);
  // R7
  mute_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs_ni) |-> $stable(mute_req));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3
    gated_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((zc_en_i || mute_req) && !xing[c] && !tick_ms_i)
        |=> $stable(act_code_o[c*CODE_W +: CODE_W]));

    // R9
    mute_hdb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mute_o[c] |-> (half_db_o[c*HDB_W +: HDB_W] == '0));

    // R9
    hdb_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mute_o[c] |-> ($signed(half_db_o[c*HDB_W +: HDB_W]) >= -191));
  end
endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_zc_gain_ctrl.sv
module sim_zc_gain_ctrl;
  localparam time PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        zc_en_i = 1'b0;
  logic        mute_ni = 1'b1;
  logic        cs_ni = 1'b1;
  logic        upd_i = 1'b0;
  logic [15:0] pend_code_i = '0;
  logic [1:0]  sign_i = '0;
  logic        tick_ms_i = 1'b0;
  logic [15:0] act_code_o;
  logic [17:0] half_db_o;
  logic [1:0]  mute_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  zc_gain_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic load(logic [7:0] c1, logic [7:0] c0);
    pend_code_i = {c1, c0};
    upd_i = 1'b1;
    step(1);
    upd_i = 1'b0;
  endtask

  task automatic flip(logic [1:0] m);
    sign_i = sign_i ^ m;
    step(5);
  endtask

  task automatic tick();
    tick_ms_i = 1'b1;
    step(1);
    tick_ms_i = 1'b0;
    step(2);
  endtask

  task automatic t_reset();
    chk("R1 code", act_code_o, 0);
    chk("R1 mute", mute_o, 2'b11);
    chk("R1 hdb", half_db_o, 0);
  endtask

  task automatic t_direct();
    zc_en_i = 1'b0;
    load(8'h3C, 8'hA5);
    step(1);
    chk("R2 code", act_code_o, 16'h3CA5);
    chk("R6 mute clear", mute_o, 2'b00);
    chk("R9 hdb ch0", half_db_o[8:0], 9'h1E5);   // -27
    chk("R9 hdb ch1", half_db_o[17:9], 9'h17C);  // -132
  endtask

  task automatic t_zc();
    zc_en_i = 1'b1;
    load(8'hC0, 8'hC0);
    step(4);
    chk("R3 held", act_code_o, 16'h3CA5);
    flip(2'b01);
    chk("R3 one xing", act_code_o, 16'h3CA5);
    flip(2'b01);
    chk("R3 two xing ch0", act_code_o, 16'h3CC0);
    flip(2'b10);
    chk("R3 ch1 one xing", act_code_o, 16'h3CC0);
  endtask

  task automatic t_timeout();
    for (int i = 0; i < 15; i++) tick();
    chk("R4 fifteen ticks", act_code_o, 16'h3CC0);
    tick();
    chk("R4 sixteenth tick", act_code_o, 16'hC0C0);
  endtask

  task automatic t_replace();
    load(8'h80, 8'h80);
    step(2);
    flip(2'b11);
    load(8'h90, 8'h90);
    step(2);
    flip(2'b11);
    chk("R5 restart", act_code_o, 16'hC0C0);
    flip(2'b11);
    chk("R5 applied", act_code_o, 16'h9090);
  endtask

  task automatic t_zero();
    zc_en_i = 1'b0;
    load(8'h90, 8'h00);
    step(1);
    chk("R6 mute flag", mute_o, 2'b01);
    chk("R9 muted hdb", half_db_o[8:0], 0);
  endtask

  task automatic t_mute_pin();
    load(8'h90, 8'h50);
    step(1);
    cs_ni = 1'b0;
    mute_ni = 1'b0;
    step(3);
    flip(2'b11);
    tick();
    chk("R7 deferred", act_code_o, 16'h9050);
    cs_ni = 1'b1;
    step(3);
    chk("R8 waits xing", act_code_o, 16'h9050);
    flip(2'b11);
    chk("R8 muted", mute_o, 2'b11);
    mute_ni = 1'b1;
    step(3);
    chk("R8 restored", act_code_o, 16'h9050);
  endtask

  task automatic t_ends();
    load(8'h01, 8'hFF);
    step(1);
    chk("R9 top", half_db_o[8:0], 9'd63);
    chk("R9 bottom", half_db_o[17:9], 9'h141);   // -191
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_direct();
    t_zc();
    t_timeout();
    t_replace();
    t_zero();
    t_mute_pin();
    t_ends();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule